// File: doc/BRIEF.md
# Three-Wire Serial Converter Host Controller

This block is the host side of a single conversion exchange with an 8-bit serial analog-to-digital converter. The converter uses a three-wire link: an active-low select, a clock and separate data lines in each direction. A request from the system carries a 2-bit input configuration. The controller selects the converter and produces the serial clock by dividing the system clock by an even parameter. It shifts out a start marker and the configuration, then stops driving its output line.

The converter answers with one filler slot, then the eight result bits with the most significant bit first. It then sends the same result again, least significant bit first, and the least significant bit is shared between the two copies. The controller throws away the filler and keeps the first copy. It collects the seven replayed bits and compares them with the first copy. It delivers the byte with a one-cycle valid strobe, plus an error flag when the two copies disagree. Between exchanges the select line stays inactive for at least one serial clock period. A request that arrives while an exchange is in progress is dropped.

Top module: `mwh_host`

## Requirements
- R1: After reset, `csN` is 1, `serClk` is 0, `serOutEn` is 0, `busy` is 0 and `resultValid` is 0.
- R2: A `startReq` sampled while idle drives `csN` low and `busy` high on the next clock edge. `busy` stays high until the cycle in which `resultValid` is 1, and in that cycle it is 0. While `csN` is low, `busy` is 1.
- R3: `serClk` is 0 whenever `csN` is high. During an exchange, each high phase and each low phase between two rising edges lasts CLK_DIV/2 system cycles. One exchange has exactly 19 rising edges.
- R4: The host drives `serOutEn`=1 with `serOut` = 1 at the first rising edge, `cfgSel[1]` at the second and `cfgSel[0]` at the third. `serOut` changes only while `serClk` is low.
- R5: From the falling edge after the third rising edge until the end of the exchange, `serOutEn` is 0. `serOutEn` is never 1 while `csN` is high.
- R6: The `serIn` value at the fourth rising edge is discarded. The values at rising edges 5 to 12 form `resultData`, bit 7 down to bit 0.
- R7: The values at rising edges 13 to 19 are taken as result bits 1 to 7. If any of them differs from the matching bit of `resultData`, `resultErr` is 1 in the valid cycle. Otherwise it is 0.
- R8: `resultValid` lasts exactly one cycle, and `resultErr` is never 1 without `resultValid`.
- R9: After the last falling edge `csN` returns high, and it stays high for at least CLK_DIV system cycles before `resultValid`.
- R10: A `startReq` while `busy` is 1 is ignored. It starts no second exchange, and it changes neither the configuration being sent nor the following idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin an exchange |
| cfgSel | input | 2 | Input configuration sent after the start marker |
| busy | output | 1 | Exchange in progress |
| resultValid | output | 1 | One-cycle strobe with the result |
| resultData | output | 8 | Converted value |
| resultErr | output | 1 | The two copies of the result disagree |
| csN | output | 1 | Active-low converter select |
| serClk | output | 1 | Serial clock to the converter |
| serOut | output | 1 | Host-to-converter data |
| serOutEn | output | 1 | High while the host drives serOut |
| serIn | input | 1 | Converter-to-host data |

## Verification
On every cycle, the assertions check several relations between the pins. The select line and busy must agree, and the clock must stay parked while deselected. Outgoing data may not move while the clock is high, and the output may not be driven without select. The valid strobe lasts a single cycle, the error flag appears only with it, and delivery happens only after the select line is released. Some behaviour can only be shown by the bench's scenarios with a modelled converter: the bit order of the start marker and configuration, the filler slot being dropped, the bit order of the assembled byte, the error raised by a corrupted replay, the exact half-period lengths and edge count, and a request dropped in the middle of an exchange.

// File: rtl/mwh_pkg.sv
package mwh_pkg;
  // Per-cycle commands from the sequencer to the datapath.
  typedef struct packed {
    logic loadTx;     // latch start marker plus configuration
    logic shiftTx;    // present next outgoing bit
    logic releaseTx;  // stop driving the outgoing line
    logic capMsb;     // take one bit of the first copy
    logic capLsb;     // take one bit of the replayed copy
    logic deliver;    // publish result and comparison outcome
  } mwhStrobe_t;
endpackage

// File: rtl/mwh_sclk_gen.sv
module mwh_sclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic serClk,
  output logic riseNow,
  output logic fallNow
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] kLast = CW'(HALF - 1);

  logic [CW-1:0] divCnt;
  logic wrap;

  assign wrap = (divCnt == kLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      serClk <= 1'b0;
    end else if (!run) begin
      divCnt <= '0;
      serClk <= 1'b0;
    end else if (wrap) begin
      divCnt <= '0;
      serClk <= ~serClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Edge markers are valid in the system cycle whose closing edge moves serClk.
  assign riseNow = run & wrap & ~serClk;
  assign fallNow = run & wrap & serClk;
endmodule

// File: rtl/mwh_ctrl.sv
module mwh_ctrl
  import mwh_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8,
  parameter int CFG_W   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       riseNow,
  input  logic       fallNow,
  output logic       run,
  output logic       csN,
  output logic       busy,
  output mwhStrobe_t strobe
);
  localparam int PRE_BITS   = 1 + CFG_W;
  localparam int RISE_TOTAL = PRE_BITS + 1 + DATA_W + (DATA_W - 1);
  localparam int BW = $clog2(RISE_TOTAL + 1);
  localparam int GW = $clog2(CLK_DIV + 1);

  localparam logic [BW-1:0] kPre      = BW'(PRE_BITS);
  localparam logic [BW-1:0] kMsbFirst = BW'(PRE_BITS + 1);
  localparam logic [BW-1:0] kMsbLast  = BW'(PRE_BITS + DATA_W);
  localparam logic [BW-1:0] kLsbFirst = BW'(PRE_BITS + DATA_W + 1);
  localparam logic [BW-1:0] kLsbLast  = BW'(RISE_TOTAL - 1);
  localparam logic [BW-1:0] kTotal    = BW'(RISE_TOTAL);
  localparam logic [GW-1:0] kGapLast  = GW'(CLK_DIV - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } mwhState_t;

  mwhState_t state;
  logic [BW-1:0] riseCnt;   // rising edges already issued
  logic [GW-1:0] gapCnt;

  always_comb begin
    strobe = '0;
    strobe.loadTx    = (state == ST_IDLE) && startReq;
    strobe.shiftTx   = (state == ST_RUN) && fallNow &&
                       (riseCnt >= BW'(1)) && (riseCnt < kPre);
    strobe.releaseTx = (state == ST_RUN) && fallNow && (riseCnt == kPre);
    strobe.capMsb    = (state == ST_RUN) && riseNow &&
                       (riseCnt >= kMsbFirst) && (riseCnt <= kMsbLast);
    strobe.capLsb    = (state == ST_RUN) && riseNow &&
                       (riseCnt >= kLsbFirst) && (riseCnt <= kLsbLast);
    strobe.deliver   = (state == ST_GAP) && (gapCnt == kGapLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      run     <= 1'b0;
      csN     <= 1'b1;
      busy    <= 1'b0;
      riseCnt <= '0;
      gapCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_RUN;
            run     <= 1'b1;
            csN     <= 1'b0;
            busy    <= 1'b1;
            riseCnt <= '0;
          end
        end
        ST_RUN: begin
          if (riseNow) begin
            riseCnt <= riseCnt + 1'b1;
          end
          if (fallNow && (riseCnt == kTotal)) begin
            state  <= ST_GAP;
            run    <= 1'b0;
            csN    <= 1'b1;
            gapCnt <= '0;
          end
        end
        ST_GAP: begin
          if (gapCnt == kGapLast) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwh_datapath.sv
module mwh_datapath
  import mwh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwhStrobe_t        strobe,
  input  logic [CFG_W-1:0]  cfgSel,
  input  logic              serIn,
  output logic              serOut,
  output logic              serOutEn,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              resultErr
);
  localparam int RW = DATA_W - 1;

  logic [CFG_W:0]    txReg;
  logic [DATA_W-1:0] msbReg;
  logic [RW-1:0]     lsbReg;   // lsbReg[i] holds replayed result bit i+1
  logic [RW-1:0]     bitDiff;
  logic              mismatch;

  assign serOut = txReg[CFG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      serOutEn <= 1'b0;
    end else if (strobe.loadTx) begin
      txReg    <= {1'b1, cfgSel};
      serOutEn <= 1'b1;
    end else if (strobe.releaseTx) begin
      txReg    <= '0;
      serOutEn <= 1'b0;
    end else if (strobe.shiftTx) begin
      txReg    <= {txReg[CFG_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msbReg <= '0;
      lsbReg <= '0;
    end else if (strobe.loadTx) begin
      msbReg <= '0;
      lsbReg <= '0;
    end else begin
      if (strobe.capMsb) msbReg <= {msbReg[DATA_W-2:0], serIn};
      if (strobe.capLsb) lsbReg <= {serIn, lsbReg[RW-1:1]};
    end
  end

  for (genvar i = 0; i < RW; i++) begin : g_cmp
    assign bitDiff[i] = lsbReg[i] ^ msbReg[i+1];
  end
  assign mismatch = |bitDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
      resultErr   <= 1'b0;
    end else begin
      resultValid <= strobe.deliver;
      resultErr   <= strobe.deliver & mismatch;
      if (strobe.deliver) resultData <= msbReg;
    end
  end
endmodule

// File: rtl/mwh_host.sv
module mwh_host
  import mwh_pkg::*;
#(
  parameter int CLK_DIV = 4,   // even, at least 2
  parameter int DATA_W  = 8,
  parameter int CFG_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CFG_W-1:0]  cfgSel,
  output logic              busy,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              resultErr,
  output logic              csN,
  output logic              serClk,
  output logic              serOut,
  output logic              serOutEn,
  input  logic              serIn
);
  mwhStrobe_t strobe;
  logic run;
  logic riseNow;
  logic fallNow;

  mwh_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk     (clk),
    .rstN    (rstN),
    .run     (run),
    .serClk  (serClk),
    .riseNow (riseNow),
    .fallNow (fallNow)
  );

  mwh_ctrl #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .riseNow  (riseNow),
    .fallNow  (fallNow),
    .run      (run),
    .csN      (csN),
    .busy     (busy),
    .strobe   (strobe)
  );

  mwh_datapath #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgSel      (cfgSel),
    .serIn       (serIn),
    .serOut      (serOut),
    .serOutEn    (serOutEn),
    .resultData  (resultData),
    .resultValid (resultValid),
    .resultErr   (resultErr)
  );
endmodule

// File: rtl/mwh_host_chk.sv
module mwh_host_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic resultValid,
  input logic resultErr,
  input logic csN,
  input logic serClk,
  input logic serOut,
  input logic serOutEn
);
  // R2: an active select always implies busy
  assert_cs_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R3: the serial clock is parked low while deselected
  assert_sclk_park_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !serClk);

  // R4: outgoing data holds while the serial clock is high
  assert_tx_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> $stable(serOut));

  // R5: the outgoing line is never driven without select
  assert_tx_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    serOutEn |-> !csN);

  // R8: valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8: the error flag only accompanies valid
  assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultErr |-> resultValid);

  // R9: delivery happens only once select is released and busy has dropped
  assert_deliver_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (csN && !busy));
endmodule

bind mwh_host mwh_host_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .resultValid (resultValid),
  .resultErr   (resultErr),
  .csN         (csN),
  .serClk      (serClk),
  .serOut      (serOut),
  .serOutEn    (serOutEn)
);

// File: tb/sim_mwh_host.sv
`timescale 1ns/1ps
module sim_mwh_host;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int RISES   = 19;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startReq;
  logic [1:0] cfgSel;
  logic       busy, resultValid, resultErr, csN, serClk, serOut, serOutEn;
  logic [7:0] resultData;
  logic       serIn = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  mwh_host #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgSel(cfgSel),
    .busy(busy), .resultValid(resultValid), .resultData(resultData),
    .resultErr(resultErr), .csN(csN), .serClk(serClk), .serOut(serOut),
    .serOutEn(serOutEn), .serIn(serIn)
  );

  // ---------------- converter model ----------------
  logic [7:0] devData = 8'h00;
  logic       devCorrupt = 1'b0;
  int         riseIdx = 0;
  int         csFalls = 0;
  logic [2:0] diBits = 3'b000;
  int         enBad = 0;
  int         releaseBad = 0;
  logic       pCs = 1'b1;
  logic       pClk = 1'b0;

  always @(csN or serClk) begin
    if (pCs === 1'b1 && csN === 1'b0) begin
      riseIdx = 0;
      csFalls++;
    end
    if (pClk === 1'b0 && serClk === 1'b1) begin
      if (riseIdx < 3) begin
        diBits[2-riseIdx] = serOut;
        if (serOutEn !== 1'b1) enBad++;
      end else if (serOutEn !== 1'b0) begin
        releaseBad++;
      end
      riseIdx++;
    end
    if (pClk === 1'b1 && serClk === 1'b0 && csN === 1'b0) begin
      if (riseIdx >= 4 && riseIdx <= 11)
        serIn = devData[11-riseIdx];
      else if (riseIdx >= 12 && riseIdx <= 18)
        serIn = devData[riseIdx-11] ^ (devCorrupt && riseIdx == 14);
      else
        serIn = 1'b0;
    end
    pCs = csN;
    pClk = serClk;
  end

  // ---------------- pin monitors ----------------
  int   runLen = 0;
  logic lastLvl = 1'b0;
  logic runFromFall = 1'b0;
  int   halfBad = 0;
  int   csHiCnt = 0;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (serClk == lastLvl) runLen++;
      else begin
        if (lastLvl || runFromFall)
          if (runLen != HALF) halfBad++;
        runFromFall = lastLvl && !csN;
        lastLvl = serClk;
        runLen = 1;
      end
      if (!csN) csHiCnt = 0;
      else if (!resultValid) csHiCnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitValid(output bit ok);
    int n = 0;
    while (resultValid !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    ok = (resultValid === 1'b1);
  endtask

  task automatic tReset();
    chk(csN === 1'b1, "R1", "csN", csN, 1);
    chk(serClk === 1'b0, "R1", "serClk", serClk, 0);
    chk(serOutEn === 1'b0, "R1", "serOutEn", serOutEn, 0);
    chk(busy === 1'b0, "R1", "busy", busy, 0);
    chk(resultValid === 1'b0, "R1", "resultValid", resultValid, 0);
  endtask

  task automatic tConvert(input logic [1:0] cfg, input logic [7:0] data,
                          input bit corrupt);
    bit ok;
    int f0 = csFalls;
    devData = data;
    devCorrupt = corrupt;
    enBad = 0;
    releaseBad = 0;
    halfBad = 0;
    @(negedge clk);
    startReq = 1'b1;
    cfgSel = cfg;
    @(negedge clk);
    startReq = 1'b0;
    chk(csN === 1'b0, "R2", "csN after start", csN, 0);
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    waitValid(ok);
    chk(ok, "R2", "valid arrived", ok, 1);
    if (!ok) return;
    chk(busy === 1'b0, "R2", "busy in valid cycle", busy, 0);
    chk(csFalls == f0 + 1, "R2", "select pulses", csFalls - f0, 1);
    chk(riseIdx == RISES, "R3", "rising edges", riseIdx, RISES);
    chk(halfBad == 0, "R3", "half-period errors", halfBad, 0);
    chk(diBits == {1'b1, cfg}, "R4", "sent header", diBits, {1'b1, cfg});
    chk(enBad == 0, "R4", "header undriven", enBad, 0);
    chk(releaseBad == 0, "R5", "driven after header", releaseBad, 0);
    chk(resultData == data, "R6", "result byte", resultData, data);
    chk(resultErr == corrupt, "R7", "copy mismatch flag", resultErr, corrupt);
    chk(csHiCnt >= CLK_DIV, "R9", "select high cycles", csHiCnt, CLK_DIV);
    @(negedge clk);
    chk(resultValid === 1'b0, "R8", "valid width", resultValid, 0);
    chk(resultErr === 1'b0, "R8", "err after valid", resultErr, 0);
  endtask

  task automatic tBusyIgnored();
    bit ok;
    int f0 = csFalls;
    devData = 8'h3C;
    devCorrupt = 1'b0;
    @(negedge clk);
    startReq = 1'b1;
    cfgSel = 2'b01;
    @(negedge clk);
    startReq = 1'b0;
    repeat (20) @(negedge clk);
    startReq = 1'b1;       // arrives mid-exchange, must be dropped
    cfgSel = 2'b10;
    @(negedge clk);
    startReq = 1'b0;
    waitValid(ok);
    chk(ok, "R10", "valid arrived", ok, 1);
    chk(diBits == 3'b101, "R10", "header kept", diBits, 3'b101);
    chk(resultData == 8'h3C, "R10", "result kept", resultData, 8'h3C);
    repeat (4 * CLK_DIV) @(negedge clk);
    chk(csFalls == f0 + 1, "R10", "exchanges started", csFalls - f0, 1);
    chk(csN === 1'b1 && busy === 1'b0, "R10", "idle after", {csN, busy}, 2'b10);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    rstN = 1'b0;
    startReq = 1'b0;
    cfgSel = 2'b00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tConvert(2'b10, 8'hA5, 1'b0);
    tConvert(2'b01, 8'h00, 1'b0);
    tConvert(2'b11, 8'hFF, 1'b0);
    tConvert(2'b00, 8'h81, 1'b1);
    tConvert(2'b10, 8'h5A, 1'b0);
    tBusyIgnored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule